// File: doc/BRIEF.md
# Shared Machine Timer with Per-Core Compare

This block holds a single 64-bit machine timer that two processor cores share, plus one 64-bit compare value for each core. Each core reaches the block through its own 32-bit register port. A write strobe, a 3-bit register select and write data go in. Read data comes back combinationally from the registers, with no wait states.

The counter advances by one on every clock where the timer is enabled and the external tick input is high. Because the counter is 64 bits wide, software sees it as two 32-bit halves. Each core can read or write either half. When both cores hit the same register in one cycle, the higher-numbered core's data lands.

Each core has its own compare value. That core's interrupt line is a level signal. It is high while the counter, taken as an unsigned 64-bit number, is at or above that compare value.

Top module: `shared_mtimer`

## Requirements
- R1: Out of reset the control enable bit and the counter are zero, both compare values are all ones, and both interrupt outputs are low.
- R2: The counter increases by exactly one on each clock where the enable bit (bit 0 of select 0) and `tick_i` are both high. On any other clock with no counter write it holds.
- R3: The register select codes are 0 = control (bit 0 enable, other bits read zero), 1 = counter bits 31:0, 2 = counter bits 63:32, 3 = this core's compare bits 31:0, 4 = this core's compare bits 63:32. Codes 5 to 7 read as zero, and writes to them change nothing.
- R4: A write to one counter half replaces the increment in that cycle, and the other half keeps the value it held before that clock.
- R5: When both cores write the same shared register (a counter half or control) in one cycle, core 1's data is stored.
- R6: When the two cores write different counter halves in one cycle, both writes take effect.
- R7: Compare writes from a core change only that core's compare value, and a core reads back only its own compare value.
- R8: Each interrupt output is high exactly when the counter is greater than or equal to that core's compare value, compared as unsigned 64-bit numbers, including when the two values differ only in the high half.
- R9: When an increment takes the low half from all ones to zero, the high half increases by one on the same clock.
- R10: A compare write that puts the compare value above the counter drops that core's interrupt on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Count qualifier; the counter may advance only while this is high |
| we_i | input | NCORE | Per-core write strobe |
| addr_i | input | 3*NCORE | Per-core register select, core c in bits [3c+2:3c] |
| wdata_i | input | 32*NCORE | Per-core write data, core c in bits [32c+31:32c] |
| rdata_o | output | 32*NCORE | Per-core read data for the selected register |
| irq_o | output | NCORE | Per-core level timer interrupt |

## Verification
The assertions take the write strobes and register selects to be known values once reset is released. They also take each core's write data to be stable across the clock edge that samples it. The interrupt-drop property further assumes that no core writes the counter in the same cycle as the compare write it watches.

The stimulus respects these assumptions by driving every input at the falling edge with fully defined values. Directed phases cover the colliding writes, the carry and the compare boundaries. A random phase then mixes all eight select codes, both strobes and the tick.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
  localparam int unsigned MT_AW = 3;

  typedef enum logic [MT_AW-1:0] {
    MT_CTRL   = 3'd0,
    MT_CNT_LO = 3'd1,
    MT_CNT_HI = 3'd2,
    MT_CMP_LO = 3'd3,
    MT_CMP_HI = 3'd4
  } mt_reg_e;
endpackage

// File: rtl/mtm_rst_sync.sv
module mtm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/mtm_counter.sv
module mtm_counter
  import mtm_pkg::*;
#(
  parameter int unsigned HW    = 32,
  parameter int unsigned NCORE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic [NCORE-1:0]      we_i,
  input  logic [NCORE*MT_AW-1:0] addr_i,
  input  logic [NCORE*HW-1:0]   wdata_i,
  output logic [2*HW-1:0]       cnt_o,
  output logic                  en_o
);
  localparam int unsigned CW = 2 * HW;
  localparam int unsigned LC = NCORE - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_q, en_d;
  logic          lo_wr, hi_wr, ctl_wr, cnt_ld;
  logic [HW-1:0] lo_val, hi_val;

  // Write arbitration: later (higher-numbered) cores override earlier ones
  always_comb begin
    lo_wr  = 1'b0;
    hi_wr  = 1'b0;
    ctl_wr = 1'b0;
    lo_val = cnt_q[HW-1:0];
    hi_val = cnt_q[CW-1:HW];
    en_d   = en_q;
    for (int c = 0; c < NCORE; c++) begin
      if (we_i[c]) begin
        case (mt_reg_e'(addr_i[c*MT_AW +: MT_AW]))
          MT_CTRL:   begin ctl_wr = 1'b1; en_d   = wdata_i[c*HW];        end
          MT_CNT_LO: begin lo_wr  = 1'b1; lo_val = wdata_i[c*HW +: HW];  end
          MT_CNT_HI: begin hi_wr  = 1'b1; hi_val = wdata_i[c*HW +: HW];  end
          default: ;
        endcase
      end
    end
  end

  // Next counter value: software write beats increment
  always_comb begin
    cnt_ld = lo_wr | hi_wr | (en_q & tick_i);
    if (lo_wr || hi_wr) cnt_d = {hi_val, lo_val};
    else                cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (cnt_ld) cnt_q <= cnt_d;
      if (ctl_wr) en_q  <= en_d;
    end
  end

  assign cnt_o = cnt_q;
  assign en_o  = en_q;

  // R2: enabled tick with no counter write advances by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_i && !lo_wr && !hi_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: no write and no enabled tick holds the counter
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en_q && tick_i) && !lo_wr && !hi_wr) |=> $stable(cnt_q));

  // R4: a low-half write leaves the high half untouched
  a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !hi_wr) |=> (cnt_q[CW-1:HW] == $past(cnt_q[CW-1:HW])));

  // R5: the last core's low-half write always lands
  a_r5_last_core_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i[LC] && addr_i[LC*MT_AW +: MT_AW] == MT_CNT_LO)
      |=> (cnt_q[HW-1:0] == $past(wdata_i[LC*HW +: HW])));

  // R9: low-half wrap carries into the high half
  a_r9_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_i && !lo_wr && !hi_wr && (&cnt_q[HW-1:0]))
      |=> (cnt_q[CW-1:HW] == $past(cnt_q[CW-1:HW]) + 1'b1));
endmodule

// File: rtl/mtm_cmp.sv
module mtm_cmp
  import mtm_pkg::*;
#(
  parameter int unsigned HW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [MT_AW-1:0] addr_i,
  input  logic [HW-1:0]    wdata_i,
  input  logic [2*HW-1:0]  cnt_i,
  output logic [2*HW-1:0]  cmp_o,
  output logic             irq_o
);
  localparam int unsigned CW = 2 * HW;

  logic [CW-1:0] cmp_q, cmp_d;
  logic          cmp_ld;

  always_comb begin
    cmp_d  = cmp_q;
    cmp_ld = 1'b0;
    if (we_i) begin
      case (mt_reg_e'(addr_i))
        MT_CMP_LO: begin cmp_ld = 1'b1; cmp_d[HW-1:0]  = wdata_i; end
        MT_CMP_HI: begin cmp_ld = 1'b1; cmp_d[CW-1:HW] = wdata_i; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_ld) cmp_q <= cmp_d;
  end

  assign cmp_o = cmp_q;
  assign irq_o = (cnt_i >= cmp_q);

  // R7: compare holds unless this core writes a compare half
  a_r7_cmp_private: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && (addr_i == MT_CMP_LO || addr_i == MT_CMP_HI)) |=> $stable(cmp_q));
endmodule

// File: rtl/shared_mtimer.sv
module shared_mtimer
  import mtm_pkg::*;
#(
  parameter int unsigned HW    = 32,
  parameter int unsigned NCORE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic [NCORE-1:0]       we_i,
  input  logic [NCORE*MT_AW-1:0] addr_i,
  input  logic [NCORE*HW-1:0]    wdata_i,
  output logic [NCORE*HW-1:0]    rdata_o,
  output logic [NCORE-1:0]       irq_o
);
  localparam int unsigned CW = 2 * HW;

  logic          rst_sn;
  logic [CW-1:0] cnt;
  logic          en;
  logic [CW-1:0] cmp [NCORE];
  logic          cnt_wr_any;

  mtm_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  mtm_counter #(.HW(HW), .NCORE(NCORE)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sn),
    .tick_i  (tick_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_o   (cnt),
    .en_o    (en)
  );

  always_comb begin
    cnt_wr_any = 1'b0;
    for (int c = 0; c < NCORE; c++) begin
      if (we_i[c] && (addr_i[c*MT_AW +: MT_AW] == MT_CNT_LO ||
                      addr_i[c*MT_AW +: MT_AW] == MT_CNT_HI))
        cnt_wr_any = 1'b1;
    end
  end

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    logic [HW-1:0]    rd;
    logic [MT_AW-1:0] sel;
    logic [HW-1:0]    wd;

    assign sel = addr_i[g*MT_AW +: MT_AW];
    assign wd  = wdata_i[g*HW +: HW];

    mtm_cmp #(.HW(HW)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_sn),
      .we_i    (we_i[g]),
      .addr_i  (sel),
      .wdata_i (wd),
      .cnt_i   (cnt),
      .cmp_o   (cmp[g]),
      .irq_o   (irq_o[g])
    );

    always_comb begin
      case (mt_reg_e'(sel))
        MT_CTRL:   rd = {{(HW-1){1'b0}}, en};
        MT_CNT_LO: rd = cnt[HW-1:0];
        MT_CNT_HI: rd = cnt[CW-1:HW];
        MT_CMP_LO: rd = cmp[g][HW-1:0];
        MT_CMP_HI: rd = cmp[g][CW-1:HW];
        default:   rd = '0;
      endcase
    end

    assign rdata_o[g*HW +: HW] = rd;

    // R10: raising the compare above the counter drops the interrupt next cycle
    a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_sn)
      (we_i[g] && sel == MT_CMP_LO && !cnt_wr_any &&
       ({1'b0, cmp[g][CW-1:HW], wd} > ({1'b0, cnt} + 1'b1)))
        |=> !irq_o[g]);
  end

  if (NCORE > 1) begin : g_pair
    // R8: equal compare values must give equal interrupt levels
    a_r8_equal_cmp_equal_irq: assert property (@(posedge clk) disable iff (!rst_sn)
      (cmp[0] == cmp[1]) |-> (irq_o[0] == irq_o[1]));
  end
endmodule

// File: tb/shared_mtimer_bench.sv
module shared_mtimer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  we_i = '0;
  logic [5:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic [1:0]  irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [63:0] m_cnt;
  logic [63:0] m_cmp [2];
  bit          m_en;

  always #5 clk = ~clk;

  shared_mtimer u_shared_mtimer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input int c, input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_en};
      3'd1: return m_cnt[31:0];
      3'd2: return m_cnt[63:32];
      3'd3: return m_cmp[c][31:0];
      3'd4: return m_cmp[c][63:32];
      default: return 32'd0;
    endcase
  endfunction

  // One clock: drive at negedge, check combinational outputs, advance model at posedge
  task automatic step(input logic [1:0] we, input logic [2:0] a0, input logic [2:0] a1,
                      input logic [31:0] d0, input logic [31:0] d1, input logic tk,
                      input string tag);
    logic [2:0]  a [2];
    logic [31:0] d [2];
    logic [63:0] nc;
    bit          ne, cw, inc;
    a[0] = a0; a[1] = a1; d[0] = d0; d[1] = d1;
    we_i = we; addr_i = {a1, a0}; wdata_i = {d1, d0}; tick_i = tk;
    #1;
    for (int c = 0; c < 2; c++) begin
      chk(tag, {32'd0, rdata_o[c*32 +: 32]}, {32'd0, mread(c, a[c])});
      chk("R8", {63'd0, irq_o[c]}, {63'd0, (m_cnt >= m_cmp[c])});
    end
    @(posedge clk);
    nc = m_cnt; ne = m_en; cw = 1'b0; inc = m_en && tk;
    for (int c = 0; c < 2; c++) begin
      if (we[c]) begin
        case (a[c])
          3'd0: ne = d[c][0];
          3'd1: begin nc[31:0]  = d[c]; cw = 1'b1; end
          3'd2: begin nc[63:32] = d[c]; cw = 1'b1; end
          3'd3: m_cmp[c][31:0]  = d[c];
          3'd4: m_cmp[c][63:32] = d[c];
          default: ;
        endcase
      end
    end
    if (!cw && inc) nc = m_cnt + 64'd1;
    m_cnt = nc;
    m_en  = ne;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL all: watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    m_cnt = '0; m_cmp[0] = '1; m_cmp[1] = '1; m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state seen through reads and interrupts
    step(2'b00, 3'd0, 3'd3, 0, 0, 1'b0, "R1");
    step(2'b00, 3'd4, 3'd1, 0, 0, 1'b0, "R1");
    step(2'b00, 3'd2, 3'd4, 0, 0, 1'b1, "R1");
    chk("R1", {62'd0, irq_o}, 64'd0);
    // R2: disabled timer ignores ticks
    step(2'b00, 3'd1, 3'd1, 0, 0, 1'b1, "R2");
    // R2: enable, then count only on ticks
    step(2'b01, 3'd0, 3'd1, 32'h1, 0, 1'b1, "R2");
    for (int i = 0; i < 6; i++) step(2'b00, 3'd1, 3'd0, 0, 0, i[0], "R2");
    // R3: high half write and readback, unused selects
    step(2'b10, 3'd0, 3'd2, 0, 32'h0000_00A5, 1'b0, "R3");
    step(2'b11, 3'd5, 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R3");
    step(2'b00, 3'd6, 3'd2, 0, 0, 1'b0, "R3");
    step(2'b00, 3'd1, 3'd0, 0, 0, 1'b0, "R3");
    // R4: low write with tick high suppresses increment, high half kept
    step(2'b01, 3'd1, 3'd2, 32'h0000_0100, 0, 1'b1, "R4");
    step(2'b00, 3'd1, 3'd2, 0, 0, 1'b0, "R4");
    // R5: colliding writes, core 1 wins
    step(2'b11, 3'd1, 3'd1, 32'h1111_1111, 32'h2222_2222, 1'b1, "R5");
    step(2'b11, 3'd0, 3'd0, 32'h1, 32'h0, 1'b0, "R5");
    step(2'b00, 3'd0, 3'd1, 0, 0, 1'b1, "R5");
    // R6: different halves in one cycle
    step(2'b11, 3'd1, 3'd2, 32'hFFFF_FFFF, 32'h0000_0005, 1'b0, "R6");
    step(2'b00, 3'd1, 3'd2, 0, 0, 1'b0, "R6");
    // R9: carry on wrap of the low half
    step(2'b01, 3'd0, 3'd0, 32'h1, 0, 1'b0, "R9");
    step(2'b00, 3'd1, 3'd2, 0, 0, 1'b1, "R9");
    step(2'b00, 3'd2, 3'd1, 0, 0, 1'b0, "R9");
    chk("R9", {32'd0, rdata_o[31:0]}, 64'h6);
    // R7: core 0 compare write, core 1 sees its own value
    step(2'b01, 3'd3, 3'd3, 32'hFFFF_FFFF, 0, 1'b0, "R7");
    step(2'b01, 3'd4, 3'd3, 32'h0000_0000, 0, 1'b0, "R7");
    step(2'b00, 3'd3, 3'd3, 0, 0, 1'b0, "R7");
    // R8: full-width compare, counter 6:0 vs compare 0:FFFFFFFF
    step(2'b00, 3'd4, 3'd4, 0, 0, 1'b0, "R8");
    chk("R8", {63'd0, irq_o[0]}, 64'd1);
    // R8: core 1 compare at counter+1, then tick reaches it
    step(2'b10, 3'd0, 3'd4, 0, 32'h6, 1'b0, "R8");
    step(2'b10, 3'd0, 3'd3, 0, 32'h1, 1'b0, "R8");
    chk("R8", {63'd0, irq_o[1]}, 64'd0);
    step(2'b00, 3'd1, 3'd3, 0, 0, 1'b1, "R8");
    chk("R8", {63'd0, irq_o[1]}, 64'd1);
    // R10: raise core 0 compare above counter, interrupt drops
    step(2'b01, 3'd4, 3'd0, 32'h7, 0, 1'b0, "R10");
    chk("R10", {63'd0, irq_o[0]}, 64'd0);
    step(2'b00, 3'd4, 3'd0, 0, 0, 1'b0, "R10");
    // Mixed random traffic across every select code
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  w;
      logic [2:0]  x0, x1;
      logic [31:0] v0, v1;
      w  = 2'($urandom_range(0, 3));
      x0 = 3'($urandom_range(0, 7));
      x1 = 3'($urandom_range(0, 7));
      v0 = $urandom();
      v1 = $urandom();
      if (x0 == 3'd2 || x0 == 3'd4) v0 = 32'($urandom_range(0, 3));
      if (x1 == 3'd2 || x1 == 3'd4) v1 = 32'($urandom_range(0, 3));
      if (x0 == 3'd0) v0 = {31'd0, 1'($urandom_range(0, 7) != 0)};
      if (x1 == 3'd0) v1 = {31'd0, 1'($urandom_range(0, 7) != 0)};
      step(w, x0, x1, v0, v1, 1'($urandom_range(0, 1)), "R3");
    end
    finish_run();
  end
endmodule